// File: doc/BRIEF.md
# Page Access Reference Counter for Migration Hints

This block counts memory accesses to each page, one counter per page and per requesting node, so that the operating system can learn which pages are used mostly from nodes other than their home. Every memory request presents a page index, the requesting node and the page's home node. In one cycle the block increments the requestor's counter and also reads the home node's counter for the same page. If the requestor's count leads the home count by more than a programmed margin, and software has marked the page as a migration candidate, the block emits a one-cycle interrupt pulse. The pulse names the page, the requestor and the home node.

Counters live in an internal register array indexed by page and by slot. In fine mode each slot belongs to one node, for systems of up to 64 nodes. In coarse mode a slot is shared by an aligned group of eight nodes, which allows larger systems. A single write port sets the margin, the per-page candidate bits and the mode, and clears all counters of one page.

Top module: `pgref_top`

## Requirements
- R1: After reset all counters read zero, no interrupt is pending, the margin is zero, every candidate bit is clear and fine mode is selected.
- R2: In fine mode the slot of a node is node[5:0]. In coarse mode it is node >> 3, so nodes 8k to 8k+7 share slot k.
- R3: Each request adds one to the requestor's slot counter of the addressed page. A counter that holds all ones keeps that value instead of wrapping.
- R4: The home count used for a request is the stored value of the home slot of that same page. Counters of other pages do not affect it.
- R5: An interrupt is raised when the incremented requestor count is greater than the home count and their unsigned difference is strictly greater than the margin.
- R6: The interrupt is a single-cycle pulse in the cycle after the request. It carries the request's page, requestor and home node. No pulse appears in a cycle that follows a cycle without a request.
- R7: No interrupt is raised when the requestor's slot equals the home slot, which includes a requestor that is the home node itself.
- R8: No interrupt is raised for a page whose candidate bit is clear.
- R9: A write with cfg_op = 0 sets the margin to cfg_data. cfg_op = 1 sets the candidate bit of cfg_page to cfg_data[0]. cfg_op = 2 clears every counter of cfg_page. cfg_op = 3 selects coarse mode when cfg_data[0] is 1. A request in the same cycle as the write still sees the old margin, candidate bits and mode.
- R10: When a clear and a request address the same page in the same cycle, the clear wins and the increment is lost. The interrupt decision for that request still uses the values read before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A memory request is present this cycle |
| req_page | input | PAGE_W | Page index of the request |
| req_node | input | NODE_W | Requesting node |
| req_home | input | NODE_W | Home node of the page |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | Write operation: 0 margin, 1 candidate bit, 2 clear page, 3 mode |
| cfg_page | input | PAGE_W | Page addressed by operations 1 and 2 |
| cfg_data | input | CNT_W | Write data |
| irq_valid | output | 1 | Migration interrupt pulse |
| irq_page | output | PAGE_W | Page that triggered the interrupt |
| irq_node | output | NODE_W | Requestor that triggered the interrupt |
| irq_home | output | NODE_W | Home node to be notified |

## Verification
The assertions assume that req_page and cfg_page stay below NUM_PAGES. They also assume that, in fine mode, node IDs fit in six bits. The stimulus picks pages only from the configured range and uses fine mode only with nodes below 24. Larger IDs, up to 127, appear only after coarse mode has been selected. A bench model of every counter predicts each interrupt. The stimulus mixes long sweeps with directed cases: saturation, a clear in the same cycle as a request, configuration writes in the same cycle as a request, and same-group requestors in coarse mode.

// File: rtl/pgref_pkg.sv
package pgref_pkg;
  typedef enum logic [1:0] {
    CFG_MARGIN = 2'd0,
    CFG_CAND   = 2'd1,
    CFG_CLEAR  = 2'd2,
    CFG_MODE   = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/pgref_slot_map.sv
module pgref_slot_map #(
  parameter int NODE_W     = 7,
  parameter int FINE_LOG2  = 6,
  parameter int GROUP_LOG2 = 3
) (
  input  logic                 coarse,
  input  logic [NODE_W-1:0]    node,
  output logic [FINE_LOG2-1:0] slot
);
  localparam int COARSE_W = NODE_W - GROUP_LOG2;

  logic [NODE_W-1:0] grouped;

  always_comb begin
    grouped = node >> GROUP_LOG2;
    if (coarse) slot = FINE_LOG2'(grouped[COARSE_W-1:0]);
    else        slot = node[FINE_LOG2-1:0];
  end
endmodule

// File: rtl/pgref_cfg.sv
module pgref_cfg
  import pgref_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int CNT_W     = 8,
  localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_op,
  input  logic [PAGE_W-1:0]    cfg_page,
  input  logic [CNT_W-1:0]     cfg_data,
  output logic [CNT_W-1:0]     margin,
  output logic [NUM_PAGES-1:0] cand,
  output logic                 coarse,
  output logic                 clr_en,
  output logic [PAGE_W-1:0]    clr_page
);
  cfg_op_e                op;
  logic [CNT_W-1:0]       margin_d;
  logic [NUM_PAGES-1:0]   cand_d;
  logic                   coarse_d;
  logic                   margin_en, cand_en, coarse_en;

  always_comb begin
    op        = cfg_op_e'(cfg_op);
    margin_en = cfg_we && (op == CFG_MARGIN);
    cand_en   = cfg_we && (op == CFG_CAND);
    coarse_en = cfg_we && (op == CFG_MODE);
    clr_en    = cfg_we && (op == CFG_CLEAR);
    clr_page  = cfg_page;
    margin_d  = cfg_data;
    coarse_d  = cfg_data[0];
    cand_d    = cand;
    cand_d[cfg_page] = cfg_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      margin <= '0;
      cand   <= '0;
      coarse <= 1'b0;
    end else begin
      if (margin_en) margin <= margin_d;
      if (cand_en)   cand   <= cand_d;
      if (coarse_en) coarse <= coarse_d;
    end
  end
endmodule

// File: rtl/pgref_counters.sv
module pgref_counters #(
  parameter int NUM_PAGES = 16,
  parameter int CNT_W     = 8,
  parameter int FINE_LOG2 = 6,
  localparam int PAGE_W   = $clog2(NUM_PAGES),
  localparam int SLOTS    = 1 << FINE_LOG2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inc_en,
  input  logic [PAGE_W-1:0]    page,
  input  logic [FINE_LOG2-1:0] req_slot,
  input  logic [FINE_LOG2-1:0] home_slot,
  input  logic                 clr_en,
  input  logic [PAGE_W-1:0]    clr_page,
  output logic [CNT_W-1:0]     req_new,
  output logic [CNT_W-1:0]     home_cnt
);
  logic [CNT_W-1:0] cnt_q   [NUM_PAGES][SLOTS];
  logic [CNT_W-1:0] cnt_d   [NUM_PAGES][SLOTS];
  logic             cell_en [NUM_PAGES][SLOTS];
  logic [CNT_W-1:0] req_cnt;
  logic             at_max;

  assign req_cnt  = cnt_q[page][req_slot];
  assign home_cnt = cnt_q[page][home_slot];
  assign at_max   = &req_cnt;
  assign req_new  = at_max ? req_cnt : req_cnt + 1'b1;

  always_comb begin
    for (int p = 0; p < NUM_PAGES; p++) begin
      for (int s = 0; s < SLOTS; s++) begin
        logic wipe;
        wipe          = clr_en && (clr_page == PAGE_W'(p));
        cell_en[p][s] = wipe || (inc_en && (page == PAGE_W'(p)) &&
                                 (req_slot == FINE_LOG2'(s)));
        cnt_d[p][s]   = wipe ? '0 : req_new;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PAGES; p++)
        for (int s = 0; s < SLOTS; s++)
          cnt_q[p][s] <= '0;
    end else begin
      for (int p = 0; p < NUM_PAGES; p++)
        for (int s = 0; s < SLOTS; s++)
          if (cell_en[p][s]) cnt_q[p][s] <= cnt_d[p][s];
    end
  end

  // Checker state: remembers the page cleared in the last cycle.
  logic              clr_seen_q;
  logic [PAGE_W-1:0] clr_page_q;
  logic              clr_page_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_seen_q <= 1'b0;
      clr_page_q <= '0;
    end else begin
      clr_seen_q <= clr_en;
      clr_page_q <= clr_page;
    end
  end

  always_comb begin
    clr_page_nz = 1'b0;
    for (int s = 0; s < SLOTS; s++)
      clr_page_nz = clr_page_nz | (|cnt_q[clr_page_q][s]);
  end

  // R3: a counter at its maximum stays there after another request
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && at_max && !(clr_en && clr_page == page))
      |=> (&cnt_q[$past(page)][$past(req_slot)]));

  // R10: after a clear the whole page reads zero, even with a request in the same cycle
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_seen_q |-> !clr_page_nz);
endmodule

// File: rtl/pgref_trigger.sv
module pgref_trigger #(
  parameter int NUM_PAGES = 16,
  parameter int CNT_W     = 8,
  parameter int NODE_W    = 7,
  localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [CNT_W-1:0]  req_new,
  input  logic [CNT_W-1:0]  home_cnt,
  input  logic [CNT_W-1:0]  margin,
  input  logic              cand,
  input  logic              same_slot,
  input  logic [PAGE_W-1:0] page,
  input  logic [NODE_W-1:0] node,
  input  logic [NODE_W-1:0] home,
  output logic              irq_valid,
  output logic [PAGE_W-1:0] irq_page,
  output logic [NODE_W-1:0] irq_node,
  output logic [NODE_W-1:0] irq_home
);
  logic [CNT_W-1:0] lead;
  logic             ahead, fire;

  always_comb begin
    ahead = req_new > home_cnt;
    lead  = req_new - home_cnt;
    fire  = valid && cand && !same_slot && ahead && (lead > margin);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_page  <= '0;
      irq_node  <= '0;
      irq_home  <= '0;
    end else begin
      irq_valid <= fire;
      if (fire) begin
        irq_page <= page;
        irq_node <= node;
        irq_home <= home;
      end
    end
  end

  // R6: a pulse only follows a request
  a_r6_pulse_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(valid));

  // R5: the requestor count read by the array led the home count
  a_r5_requestor_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ($past(req_new) > $past(home_cnt)));

  // R7: the home node never signals itself
  a_r7_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_node != irq_home));
endmodule

// File: rtl/pgref_top.sv
module pgref_top #(
  parameter int NUM_PAGES  = 16,
  parameter int NODE_W     = 7,
  parameter int CNT_W      = 8,
  parameter int FINE_LOG2  = 6,
  parameter int GROUP_LOG2 = 3,
  localparam int PAGE_W    = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [NODE_W-1:0] req_node,
  input  logic [NODE_W-1:0] req_home,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_op,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic [CNT_W-1:0]  cfg_data,
  output logic              irq_valid,
  output logic [PAGE_W-1:0] irq_page,
  output logic [NODE_W-1:0] irq_node,
  output logic [NODE_W-1:0] irq_home
);
  logic [CNT_W-1:0]     margin;
  logic [NUM_PAGES-1:0] cand;
  logic                 coarse;
  logic                 clr_en;
  logic [PAGE_W-1:0]    clr_page;
  logic [FINE_LOG2-1:0] req_slot, home_slot;
  logic [CNT_W-1:0]     req_new, home_cnt;

  pgref_cfg #(.NUM_PAGES(NUM_PAGES), .CNT_W(CNT_W)) u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_op, .cfg_page, .cfg_data,
    .margin, .cand, .coarse, .clr_en, .clr_page
  );

  pgref_slot_map #(.NODE_W(NODE_W), .FINE_LOG2(FINE_LOG2), .GROUP_LOG2(GROUP_LOG2))
    u_req_map (.coarse(coarse), .node(req_node), .slot(req_slot));

  pgref_slot_map #(.NODE_W(NODE_W), .FINE_LOG2(FINE_LOG2), .GROUP_LOG2(GROUP_LOG2))
    u_home_map (.coarse(coarse), .node(req_home), .slot(home_slot));

  pgref_counters #(.NUM_PAGES(NUM_PAGES), .CNT_W(CNT_W), .FINE_LOG2(FINE_LOG2)) u_cnt (
    .clk, .rst_n, .inc_en(req_valid), .page(req_page), .req_slot, .home_slot,
    .clr_en, .clr_page, .req_new, .home_cnt
  );

  pgref_trigger #(.NUM_PAGES(NUM_PAGES), .CNT_W(CNT_W), .NODE_W(NODE_W)) u_trig (
    .clk, .rst_n, .valid(req_valid), .req_new, .home_cnt, .margin,
    .cand(cand[req_page]), .same_slot(req_slot == home_slot),
    .page(req_page), .node(req_node), .home(req_home),
    .irq_valid, .irq_page, .irq_node, .irq_home
  );

  // R8: a pulse implies the page was a candidate when the request arrived
  a_r8_candidate_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(cand[req_page]));
endmodule

// File: tb/tb_pgref_top.sv
`timescale 1ns/1ps
module tb_pgref_top;
  localparam int PAGES = 4;
  localparam int CW    = 4;
  localparam int NW    = 7;
  localparam int PW    = 2;
  localparam int MAXC  = (1 << CW) - 1;

  logic          clk, rst_n;
  logic          req_valid;
  logic [PW-1:0] req_page;
  logic [NW-1:0] req_node, req_home;
  logic          cfg_we;
  logic [1:0]    cfg_op;
  logic [PW-1:0] cfg_page;
  logic [CW-1:0] cfg_data;
  logic          irq_valid;
  logic [PW-1:0] irq_page;
  logic [NW-1:0] irq_node, irq_home;

  int checks = 0, errors = 0;
  bit done = 0;

  int  mcnt [PAGES][64];
  int  mthr;
  bit  mcand [PAGES];
  bit  mcoarse;

  pgref_top #(.NUM_PAGES(PAGES), .NODE_W(NW), .CNT_W(CW)) dut (
    .clk, .rst_n, .req_valid, .req_page, .req_node, .req_home,
    .cfg_we, .cfg_op, .cfg_page, .cfg_data,
    .irq_valid, .irq_page, .irq_node, .irq_home
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic int slot_of(int n);
    return mcoarse ? (n >> 3) : (n & 63);
  endfunction

  task automatic step(bit rv, int pg, int rn, int hn,
                      bit cw, int op, int cp, int cd, string tag);
    bit exp; int rs, hs, rc, hc, nw; string t;
    req_valid = rv; req_page = PW'(pg); req_node = NW'(rn); req_home = NW'(hn);
    cfg_we = cw; cfg_op = 2'(op); cfg_page = PW'(cp); cfg_data = CW'(cd);
    exp = 0; t = "R6";
    if (rv) begin
      rs = slot_of(rn); hs = slot_of(hn);
      rc = mcnt[pg][rs]; hc = mcnt[pg][hs];
      nw = (rc == MAXC) ? rc : rc + 1;
      exp = mcand[pg] && (rs != hs) && (nw > hc) && ((nw - hc) > mthr);
      if (exp) t = "R5";
      else if (rs == hs) t = "R7";
      else if (!mcand[pg]) t = "R8";
      else t = "R5";
      mcnt[pg][rs] = nw;
    end
    if (tag != "") t = tag;
    if (cw) begin
      case (op)
        0: mthr = cd;
        1: mcand[cp] = cd[0];
        2: for (int s = 0; s < 64; s++) mcnt[cp][s] = 0;
        default: mcoarse = cd[0];
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    checks++;
    if (irq_valid !== exp) begin
      errors++;
      $display("FAIL %s: irq_valid=%0b expected %0b (page %0d node %0d home %0d)",
               t, irq_valid, exp, pg, rn, hn);
    end else if (exp) begin
      checks++;
      if (irq_page !== PW'(pg) || irq_node !== NW'(rn) || irq_home !== NW'(hn)) begin
        errors++;
        $display("FAIL R6: fields %0d/%0d/%0d expected %0d/%0d/%0d",
                 irq_page, irq_node, irq_home, pg, rn, hn);
      end
    end
  endtask

  task automatic cfg(int op, int cp, int cd);
    step(0, 0, 0, 0, 1, op, cp, cd, "R9");
  endtask

  task automatic req(int pg, int rn, int hn, string tag);
    step(1, pg, rn, hn, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < PAGES; p++) begin
      mcand[p] = 0;
      for (int s = 0; s < 64; s++) mcnt[p][s] = 0;
    end
    mthr = 0; mcoarse = 0;
    rst_n = 0; req_valid = 0; req_page = 0; req_node = 0; req_home = 0;
    cfg_we = 0; cfg_op = 0; cfg_page = 0; cfg_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: nothing pending after reset
    checks++;
    if (irq_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: irq_valid=%0b expected 0", irq_valid);
    end
    // R1/R8: candidate bits clear after reset, so no pulse
    req(0, 1, 2, "R1");
    req(0, 1, 2, "R1");

    // R3: saturation, margin 0, home never requests
    cfg(1, 1, 1);
    for (int k = 0; k < 20; k++) req(1, 1, 2, "R3");

    // R4: home traffic on page 0 does not affect page 2
    cfg(1, 2, 1);
    for (int k = 0; k < 6; k++) req(0, 2, 2, "R7");
    req(2, 5, 2, "R4");

    // R9: margin written in the same cycle as a request: old margin applies
    step(1, 2, 6, 2, 1, 0, 0, 3, "R9");
    req(2, 6, 2, "R9");
    req(2, 6, 2, "R9");
    req(2, 6, 2, "R9");
    // R9: candidate cleared in the same cycle as a request
    step(1, 2, 6, 2, 1, 1, 2, 0, "R9");
    req(2, 6, 2, "R8");

    // R10: clear and request to the same page in one cycle
    cfg(0, 0, 0);
    step(1, 1, 1, 2, 1, 2, 1, 0, "R10");
    req(1, 1, 2, "R10");
    req(1, 1, 2, "R10");

    // Sweep in fine mode
    cfg(0, 0, 3);
    cfg(1, 0, 1); cfg(1, 1, 1); cfg(1, 3, 1);
    for (int i = 0; i < 800; i++) begin
      int pg, rn, hn;
      pg = (i / 5) % PAGES;
      rn = (i * 13 + i / 11) % 24;
      hn = 8 + (i % 3);
      if (i % 97 == 96)       step(1, pg, rn, hn, 1, 2, (i / 97) % PAGES, 0, "R10");
      else if (i % 150 == 149) step(1, pg, rn, hn, 1, 0, 0, (i / 150) % 6, "R9");
      else                     req(pg, rn, hn, "");
    end

    // R2: switch to coarse mode; nodes 64 and 70 share a slot
    cfg(3, 0, 1);
    cfg(0, 0, 0);
    cfg(1, 0, 1);
    cfg(2, 0, 0);
    for (int k = 0; k < 4; k++) req(0, 70, 64, "R2");
    req(0, 75, 64, "R2");
    for (int i = 0; i < 800; i++) begin
      int pg, rn, hn;
      pg = (i / 7) % PAGES;
      rn = (i * 29 + i / 13) % 128;
      hn = 64 + 8 * (i % 2) + (i % 5);
      if (i % 101 == 100)     step(1, pg, rn, hn, 1, 1, (i / 101) % PAGES, i / 101, "R9");
      else if (i % 89 == 88)  step(1, pg, rn, hn, 1, 2, pg, 0, "R10");
      else                    req(pg, rn, hn, "");
    end

    // R6: idle cycles produce no pulse
    step(0, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R6");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule